// File: doc/BRIEF.md
# Conditional Move Decoder for a Port-Addressed Datapath

This block is the issue stage of a datapath in which every instruction is a single data transfer between numbered ports. It fetches one 16-bit move per cycle from an instruction store at the address it drives.

It tests the move's condition against a flag input. When the condition holds, it places the source and destination port numbers on two address buses and raises a transfer strobe. During the strobe it puts the transferred value on the data bus, and the destination unit loads that value at the next rising clock edge.

The source of a move can be one of three things:
- a sign-extended short literal carried in the move itself;
- one of three built-in constant ports, which give 0, 1 and all-ones;
- any other output port, whose value and ready flag arrive on the source return inputs.

A move whose external source is not ready stalls. The move stays presented and the instruction address does not advance until the source reports ready.

Move layout, most significant bit first:

| Bits | Field |
|------|-------|
| [15:14] | Condition code |
| [13] | Literal flag |
| [12:7] | Source port number, or the literal |
| [6:0] | Destination port number |

Top module: `ttm_move_decoder`

## Requirements
- R1: While `rst_n` is low, and for the first two rising edges after it goes high, `instr_addr` is 0, `xfer_strobe` is low and `bus_data` is 0.
- R2: Condition codes are: 2'b00 always, 2'b01 pass when `test_flag` is 1, 2'b10 pass when `test_flag` is 0, 2'b11 never. A move whose condition fails raises no strobe, drives 0 on `src_port`, `dst_port` and `bus_data`, and advances `instr_addr` by one at the next edge.
- R3: A passing non-literal move whose source is ready raises `xfer_strobe` in the same cycle. In that cycle it drives `src_port` = bits [12:7], `dst_port` = bits [6:0] and `bus_data` = `src_rdata`, and `instr_addr` advances by one at the next edge.
- R4: A passing non-literal move to a source port of 3 or above with `src_ready` low keeps `xfer_strobe` low and `bus_data` at 0. It keeps `src_port` and `dst_port` presented and holds `instr_addr` until `src_ready` rises.
- R5: With bit 13 set, a passing move drives `bus_data` with bits [12:7] sign-extended to the data width. It drives `src_port` = 0 and strobes without regard to `src_ready`.
- R6: Source ports 0, 1 and 2 are internal constants giving 0, 1 and all-ones. A move from them strobes without regard to `src_ready`.
- R7: `instr_addr` wraps from its largest value to 0.
- R8: `bus_data` is 0 in every cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| test_flag | input | 1 | Flag bit tested by condition codes 01 and 10 |
| instr_data | input | 16 | Move word stored at `instr_addr` |
| src_ready | input | 1 | Ready flag of the external output port named on `src_port` |
| src_rdata | input | DATA_W | Value of the external output port named on `src_port` |
| instr_addr | output | IP_W | Instruction address |
| src_port | output | 6 | Source address bus |
| dst_port | output | 7 | Destination address bus |
| xfer_strobe | output | 1 | Transfer strobe; the destination loads at the next edge |
| bus_data | output | DATA_W | Data bus |

## Verification
On every cycle, assertions check how the instruction address moves: it steps by one after a strobe or a failed condition, and it holds during a stall. They also check that literal moves and constant-port moves never wait for the ready input.

The bench's scenarios are what show the values themselves. These are the condition decoding under both flag values, sign extension at the literal extremes, the three constant values, a stall held for several cycles then released, and address wrap with the program re-run.

// File: rtl/ttm_pkg.sv
package ttm_pkg;

  localparam int MOVE_W = 16;
  localparam int SRC_W  = 6;
  localparam int DST_W  = 7;
  localparam int N_CONST = 3;

  typedef enum logic [1:0] {
    C_ALWAYS = 2'b00,
    C_FSET   = 2'b01,
    C_FCLR   = 2'b10,
    C_NEVER  = 2'b11
  } cond_e;

  typedef struct packed {
    cond_e             cond;
    logic              lit;
    logic [SRC_W-1:0]  src;
    logic [DST_W-1:0]  dst;
  } move_t;

endpackage

// File: rtl/ttm_cond_eval.sv
module ttm_cond_eval
  import ttm_pkg::*;
(
  input  cond_e cond,
  input  logic  flag,
  output logic  pass
);

  always_comb begin
    unique case (cond)
      C_ALWAYS: pass = 1'b1;
      C_FSET:   pass = flag;
      C_FCLR:   pass = ~flag;
      default:  pass = 1'b0;
    endcase
  end

endmodule

// File: rtl/ttm_const_unit.sv
module ttm_const_unit #(
  parameter int DATA_W = 16,
  parameter int PORT_W = 6,
  parameter int NUM    = 3
) (
  input  logic [PORT_W-1:0] port,
  output logic              hit,
  output logic [DATA_W-1:0] value
);

  logic [NUM-1:0]    sel;
  logic [DATA_W-1:0] table_q [NUM];

  function automatic logic [DATA_W-1:0] const_of(input int k);
    case (k)
      0:       const_of = '0;
      1:       const_of = DATA_W'(1);
      default: const_of = '1;
    endcase
  endfunction

  for (genvar k = 0; k < NUM; k++) begin : g_const
    assign sel[k]     = (port == PORT_W'(k));
    assign table_q[k] = const_of(k);
  end

  always_comb begin
    value = '0;
    for (int k = 0; k < NUM; k++) begin
      if (sel[k]) value = value | table_q[k];
    end
  end

  assign hit = |sel;

endmodule

// File: rtl/ttm_src_mux.sv
module ttm_src_mux #(
  parameter int DATA_W = 16,
  parameter int LIT_W  = 6
) (
  input  logic              go,
  input  logic              lit,
  input  logic [LIT_W-1:0]  lit_field,
  input  logic              const_hit,
  input  logic [DATA_W-1:0] const_val,
  input  logic              ext_ready,
  input  logic [DATA_W-1:0] ext_data,
  output logic              ready,
  output logic [DATA_W-1:0] data
);

  localparam int EXT_W = DATA_W - LIT_W;

  logic [DATA_W-1:0] lit_sx;

  assign lit_sx = {{EXT_W{lit_field[LIT_W-1]}}, lit_field};
  assign ready  = lit | const_hit | ext_ready;

  always_comb begin
    data = '0;
    if (go) begin
      if (lit)            data = lit_sx;
      else if (const_hit) data = const_val;
      else                data = ext_data;
    end
  end

endmodule

// File: rtl/ttm_ip_seq.sv
module ttm_ip_seq #(
  parameter int IP_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  output logic [IP_W-1:0] ip
);

  logic [IP_W-1:0] ip_q;
  logic [IP_W-1:0] ip_d;
  logic            ip_en;

  assign ip_en = advance;
  assign ip_d  = ip_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ip_q <= '0;
    else if (ip_en) ip_q <= ip_d;
  end

  assign ip = ip_q;

endmodule

// File: rtl/ttm_move_decoder.sv
module ttm_move_decoder
  import ttm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IP_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_flag,
  input  logic [MOVE_W-1:0] instr_data,
  input  logic              src_ready,
  input  logic [DATA_W-1:0] src_rdata,
  output logic [IP_W-1:0]   instr_addr,
  output logic [SRC_W-1:0]  src_port,
  output logic [DST_W-1:0]  dst_port,
  output logic              xfer_strobe,
  output logic [DATA_W-1:0] bus_data
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s      <= rst_meta_q;
    end
  end

  move_t             mv;
  logic              cond_ok;
  logic              pass;
  logic              const_hit;
  logic [DATA_W-1:0] const_val;
  logic              src_ok;
  logic              stall;
  logic              advance;

  assign mv = move_t'(instr_data);

  ttm_cond_eval u_cond (
    .cond (mv.cond),
    .flag (test_flag),
    .pass (cond_ok)
  );

  ttm_const_unit #(
    .DATA_W (DATA_W),
    .PORT_W (SRC_W),
    .NUM    (N_CONST)
  ) u_const (
    .port  (mv.src),
    .hit   (const_hit),
    .value (const_val)
  );

  assign pass = rst_s & cond_ok;

  ttm_src_mux #(
    .DATA_W (DATA_W),
    .LIT_W  (SRC_W)
  ) u_mux (
    .go        (xfer_strobe),
    .lit       (mv.lit),
    .lit_field (mv.src),
    .const_hit (const_hit),
    .const_val (const_val),
    .ext_ready (src_ready),
    .ext_data  (src_rdata),
    .ready     (src_ok),
    .data      (bus_data)
  );

  assign xfer_strobe = pass & src_ok;
  assign stall       = pass & ~src_ok;
  assign advance     = rst_s & (~cond_ok | src_ok);

  assign src_port = (pass && !mv.lit) ? mv.src : '0;
  assign dst_port = pass ? mv.dst : '0;

  ttm_ip_seq #(
    .IP_W (IP_W)
  ) u_ip (
    .clk     (clk),
    .rst_n   (rst_s),
    .advance (advance),
    .ip      (instr_addr)
  );

  // R3: a completed transfer moves on to the next move
  a_r3_step_after_xfer: assert property (@(posedge clk) disable iff (!rst_s)
    xfer_strobe |=> instr_addr == IP_W'($past(instr_addr) + 1'b1));

  // R2: a failed condition skips the move
  a_r2_skip_failed: assert property (@(posedge clk) disable iff (!rst_s)
    !cond_ok |=> instr_addr == IP_W'($past(instr_addr) + 1'b1));

  // R4: a stalled move stays presented
  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_s)
    stall |=> $stable(instr_addr));

  // R5: a literal never waits on the ready input
  a_r5_lit_no_wait: assert property (@(posedge clk) disable iff (!rst_s)
    (cond_ok && mv.lit) |-> xfer_strobe);

  // R6: constant ports never wait on the ready input
  a_r6_const_no_wait: assert property (@(posedge clk) disable iff (!rst_s)
    (cond_ok && !mv.lit && mv.src < SRC_W'(N_CONST)) |-> xfer_strobe);

  // R8: the data bus is quiet without a strobe
  a_r8_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_strobe |-> bus_data == '0);

endmodule

// File: tb/ttm_move_decoder_test.sv
module ttm_move_decoder_test;

  localparam int DW  = 16;
  localparam int IPW = 6;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           test_flag;
  logic [15:0]    instr_data;
  logic           src_ready;
  logic [DW-1:0]  src_rdata;
  logic [IPW-1:0] instr_addr;
  logic [5:0]     src_port;
  logic [6:0]     dst_port;
  logic           xfer_strobe;
  logic [DW-1:0]  bus_data;

  logic [15:0] mem [64];
  logic [63:0] rdy;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  ttm_move_decoder #(.DATA_W(DW), .IP_W(IPW)) uut (
    .clk(clk), .rst_n(rst_n), .test_flag(test_flag), .instr_data(instr_data),
    .src_ready(src_ready), .src_rdata(src_rdata), .instr_addr(instr_addr),
    .src_port(src_port), .dst_port(dst_port), .xfer_strobe(xfer_strobe),
    .bus_data(bus_data)
  );

  // instruction store and external port stubs
  assign instr_data = mem[instr_addr];
  assign src_ready  = rdy[src_port];
  assign src_rdata  = 16'hA000 | DW'(src_port);

  typedef struct {
    logic [5:0]    src;
    logic [6:0]    dst;
    logic [DW-1:0] data;
    string         req;
  } xfer_t;

  xfer_t exp_q[$];

  function automatic logic [15:0] mv(input logic [1:0] c, input logic l,
                                     input logic [5:0] s, input logic [6:0] d);
    return {c, l, s, d};
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_xfer(input logic [5:0] s, input logic [6:0] d,
                             input logic [DW-1:0] v, input string req);
    xfer_t x;
    x.src = s; x.dst = d; x.data = v; x.req = req;
    exp_q.push_back(x);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    #2;
  endtask

  // monitor: every strobe is compared with the next expected transfer
  always @(negedge clk) begin
    if (rst_n && xfer_strobe) begin
      if (exp_q.size() == 0) begin
        check("unexpected strobe", {25'd0, dst_port}, 32'h7f);
      end else begin
        xfer_t x;
        x = exp_q.pop_front();
        check({x.req, " dst"},  {25'd0, dst_port}, {25'd0, x.dst});
        check({x.req, " src"},  {26'd0, src_port}, {26'd0, x.src});
        check({x.req, " data"}, {16'd0, bus_data}, {16'd0, x.data});
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    test_flag = 1'b1;
    rdy = '1;
    for (int i = 0; i < 64; i++) mem[i] = mv(2'b11, 1'b0, 6'd0, 7'd0);

    // ---------- program 1: flag = 1 ----------
    mem[0] = mv(2'b00, 0, 6'd5,  7'd9);   // always
    mem[1] = mv(2'b01, 0, 6'd7,  7'd3);   // flag set, passes
    mem[2] = mv(2'b10, 0, 6'd8,  7'd4);   // flag clear, skipped
    mem[3] = mv(2'b11, 0, 6'd9,  7'd5);   // never
    mem[4] = mv(2'b00, 1, 6'h3F, 7'd10);  // literal -1
    mem[5] = mv(2'b00, 1, 6'h1F, 7'd11);  // literal +31
    mem[6] = mv(2'b00, 1, 6'h20, 7'd12);  // literal -32
    mem[7] = mv(2'b00, 0, 6'd0,  7'd13);  // const 0
    mem[8] = mv(2'b00, 0, 6'd1,  7'd14);  // const 1
    mem[9] = mv(2'b00, 0, 6'd2,  7'd15);  // const -1
    rdy[0] = 1'b0; rdy[1] = 1'b0; rdy[2] = 1'b0;  // ready must be ignored

    expect_xfer(6'd5, 7'd9,  16'hA005, "R3 always move");
    expect_xfer(6'd7, 7'd3,  16'hA007, "R2 flag-set move");
    expect_xfer(6'd0, 7'd10, 16'hFFFF, "R5 literal -1");
    expect_xfer(6'd0, 7'd11, 16'h001F, "R5 literal +31");
    expect_xfer(6'd0, 7'd12, 16'hFFE0, "R5 literal -32");
    expect_xfer(6'd0, 7'd13, 16'h0000, "R6 const zero");
    expect_xfer(6'd1, 7'd14, 16'h0001, "R6 const one");
    expect_xfer(6'd2, 7'd15, 16'hFFFF, "R6 const all-ones");

    repeat (3) @(posedge clk);
    #2;
    check("R1 reset addr",   {26'd0, instr_addr}, 32'd0);
    check("R1 reset strobe", {31'd0, xfer_strobe}, 32'd0);
    check("R1 reset bus",    {16'd0, bus_data}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    tick(1);
    check("R1 sync release strobe", {31'd0, xfer_strobe}, 32'd0);
    check("R1 sync release addr",   {26'd0, instr_addr}, 32'd0);
    tick(15);  // 16 edges since release: address 14
    check("R2 skipped moves, queue drained", exp_q.size(), 32'd0);
    check("R8 bus quiet on never move", {16'd0, bus_data}, 32'd0);

    // second pass after wrap: addresses 0,1 then 4 visible at sample
    expect_xfer(6'd5, 7'd9,  16'hA005, "R7 wrap re-run 0");
    expect_xfer(6'd7, 7'd3,  16'hA007, "R7 wrap re-run 1");
    expect_xfer(6'd0, 7'd10, 16'hFFFF, "R7 wrap re-run 4");
    tick(54);  // 70 edges: address 68 mod 64 = 4
    check("R7 address wrapped", {26'd0, instr_addr}, 32'd4);
    check("R7 re-run queue drained", exp_q.size(), 32'd0);

    // ---------- program 2: flag = 0, stall ----------
    rst_n = 1'b0;
    test_flag = 1'b0;
    rdy = '1;
    rdy[40] = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = mv(2'b11, 1'b0, 6'd0, 7'd0);
    mem[0] = mv(2'b10, 0, 6'd5,  7'd20);  // flag clear, passes
    mem[1] = mv(2'b01, 0, 6'd6,  7'd22);  // flag set, skipped
    mem[2] = mv(2'b00, 0, 6'd40, 7'd21);  // stalls
    expect_xfer(6'd5,  7'd20, 16'hA005, "R2 flag-clear move");
    expect_xfer(6'd40, 7'd21, 16'hA028, "R4 move after stall");

    tick(2);
    rst_n = 1'b1;
    tick(10);
    check("R4 stall holds addr",  {26'd0, instr_addr}, 32'd2);
    check("R4 stall no strobe",   {31'd0, xfer_strobe}, 32'd0);
    check("R4 stall src shown",   {26'd0, src_port}, 32'd40);
    check("R4 stall dst shown",   {25'd0, dst_port}, 32'd21);
    check("R8 stall bus quiet",   {16'd0, bus_data}, 32'd0);
    check("R4 one move done",     exp_q.size(), 32'd1);
    @(posedge clk);
    #1;
    rdy[40] = 1'b1;
    tick(2);
    check("R4 released addr",     {26'd0, instr_addr}, 32'd4);
    check("R4 queue drained",     exp_q.size(), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule